// File: doc/BRIEF.md
# Serial-Loaded Latched Segment Driver

This block takes a 16-bit pattern over a three-wire serial link (an active-low select, a serial clock and a data line) and holds it in an output latch. Each latch bit enables one segment. While select is high, the latch follows the shift register, which does not move in that state. While select is low, the latch is frozen and the shift register takes one bit on each rising edge of the serial clock. The rising edge of select puts the new pattern on the outputs.

The last shift stage is also driven out as a serial output. A second device on the same select and serial clock therefore receives every bit that overflows this one. A lamp-test input turns every segment on without disturbing the latch.

All three serial inputs are resynchronised to the system clock. Edges are found from the resynchronised copies. A three-state controller sequences each frame:
- `ST_IDLE`: select is high and the latch tracks the register. It moves to `ST_SHIFT` when select is seen low.
- `ST_SHIFT`: the latch is frozen and rising serial-clock edges shift. It moves to `ST_COMMIT` when select is seen high.
- `ST_COMMIT`: the latch loads the fresh pattern. It returns to `ST_SHIFT` if select is already low again, and otherwise goes to `ST_IDLE`.

Top module: `segdrv_top`

## Requirements
- R1: After reset every segment output is 0 (off) and the serial output is 0.
- R2: After a 16-bit frame and a rising select edge, segment output k equals the bit shifted in (16 - k)th. The first bit shifted lands on index 15. A 1 turns a segment on and a 0 turns it off.
- R3: While select is low, the segment outputs keep their previous value, whatever bits are shifted.
- R4: A few system clocks after select rises, the segment outputs show the newly shifted pattern.
- R5: Rising serial-clock edges while select is high change neither the shift register nor the outputs.
- R6: The serial output equals shift stage 15. In a frame longer than 16 bits, it presents the earliest bits again in the order they were sent, one per rising serial-clock edge.
- R7: While lamp test is 1, all 16 segment outputs are 1. Releasing lamp test restores the latched pattern.
- R8: A frame that starts and ends with the serial clock high inside the select-low window is captured completely, with no spurious shift at either boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, sampled on its rising edge |
| sdin | input | 1 | Serial data in |
| lamp_test | input | 1 | 1 forces all segments on |
| sdout | output | 1 | Cascade output from shift stage 15 |
| seg_on | output | 16 | Segment enables, 1 = on |

## Verification
The bench builds the block with its default width of 16 and two synchroniser stages. Each serial half-period is four system clocks, which covers the synchroniser and edge-detect latency, so every bit lands on a known system cycle. Because the width is 16, a 20-bit frame reaches the overflow path: the four extra bits can be followed on the cascade output one by one. At the same width the bench can also check that the outputs hold mid-frame and follow the latch while select is high.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN = STAGES * W;

    logic [CHAIN-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[CHAIN-W-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN-1 -: W];
endmodule

// File: rtl/segdrv_fsm.sv
module segdrv_fsm
    import segdrv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n_s,
    input  logic         sclk_s,
    output frame_state_t state,
    output logic         shift_en,
    output logic         latch_en
);
    frame_state_t state_nx;
    logic         sclk_d;
    logic         sclk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sclk_d <= 1'b1;
        end else begin
            state  <= state_nx;
            sclk_d <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!sel_n_s) state_nx = ST_SHIFT;
            ST_SHIFT:  if (sel_n_s)  state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = sel_n_s ? ST_IDLE : ST_SHIFT;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        latch_en = 1'b0;
        unique case (state)
            ST_IDLE:   latch_en = 1'b1;
            ST_SHIFT:  shift_en = sclk_rise & ~sel_n_s;
            ST_COMMIT: latch_en = 1'b1;
            default:   latch_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/segdrv_datapath.sv
module segdrv_datapath #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             latch_en,
    input  logic             din,
    input  logic             lamp_test,
    output logic [WIDTH-1:0] shreg,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] seg_on,
    output logic             sdout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[WIDTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= '0;
        else if (latch_en) latch_q <= shreg;
    end

    assign seg_on = latch_q | {WIDTH{lamp_test}};
    assign sdout  = shreg[WIDTH-1];
endmodule

// File: rtl/segdrv_top.sv
module segdrv_top
    import segdrv_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sclk,
    input  logic             sdin,
    input  logic             lamp_test,
    output logic             sdout,
    output logic [WIDTH-1:0] seg_on
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn_in;
    frame_state_t     state;
    logic             shift_en;
    logic             latch_en;
    logic [WIDTH-1:0] shreg;
    logic [WIDTH-1:0] latch_q;

    assign raw_in = {sel_n, sclk, sdin};

    segdrv_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    segdrv_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (syn_in[2]),
        .sclk_s   (syn_in[1]),
        .state    (state),
        .shift_en (shift_en),
        .latch_en (latch_en)
    );

    segdrv_datapath #(
        .WIDTH (WIDTH)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .latch_en  (latch_en),
        .din       (syn_in[0]),
        .lamp_test (lamp_test),
        .shreg     (shreg),
        .latch_q   (latch_q),
        .seg_on    (seg_on),
        .sdout     (sdout)
    );
endmodule

// File: rtl/segdrv_chk.sv
module segdrv_chk
    import segdrv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lamp_test,
    input logic             sdout,
    input logic [WIDTH-1:0] seg_on,
    input frame_state_t     state,
    input logic             shift_en,
    input logic [WIDTH-1:0] shreg,
    input logic [WIDTH-1:0] latch_q
);
    // R3: latch frozen across every cycle spent shifting
    p_hold_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> $stable(latch_q));

    // R4: commit cycle moves the register contents into the latch
    p_commit_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (latch_q == $past(shreg)));

    // R5: no shifting outside the select-low window
    p_idle_no_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(shreg));

    // R6: after a shift the cascade output carries the former stage 14
    p_cascade_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sdout == $past(shreg[WIDTH-2])));

    // R7: lamp test lights every segment
    p_lamp_all_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_test |-> (&seg_on));

    // R2: no lamp test means outputs equal the latch exactly
    p_seg_from_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_test && $stable(latch_q)) |-> (seg_on == $past(latch_q)));
endmodule

bind segdrv_top segdrv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lamp_test (lamp_test),
    .sdout     (sdout),
    .seg_on    (seg_on),
    .state     (state),
    .shift_en  (shift_en),
    .shreg     (shreg),
    .latch_q   (latch_q)
);

// File: tb/segdrv_top_test.sv
module segdrv_top_test;
    localparam int W = 16;
    localparam int NVEC = 6;
    localparam logic [W-1:0] VEC_DATA [NVEC] = '{16'hFFFF, 16'h0000, 16'h8001, 16'hA55A, 16'h0F0F, 16'h7E81};
    localparam logic [W-1:0] VEC_EXP  [NVEC] = '{16'hFFFF, 16'h0000, 16'h8001, 16'hA55A, 16'h0F0F, 16'h7E81};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_n = 1'b1;
    logic         sclk = 1'b1;
    logic         sdin = 1'b0;
    logic         lamp_test = 1'b0;
    logic         sdout;
    logic [W-1:0] seg_on;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    segdrv_top #(.WIDTH(W), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .sclk      (sclk),
        .sdin      (sdin),
        .lamp_test (lamp_test),
        .sdout     (sdout),
        .seg_on    (seg_on)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_open();
        sel_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic frame_close();
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic put_bit(input logic b);
        sclk = 1'b0;
        sdin = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
    endtask

    task automatic put_word(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [19:0] long_w;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 seg after reset", 32'(seg_on), 32'h0);
        chk("R1 sdout after reset", 32'(sdout), 32'h0);

        // table of frames, first bit sent is bit 15
        for (int i = 0; i < NVEC; i++) begin
            frame_open();
            put_word(32'(VEC_DATA[i]), W);
            frame_close();
            chk("R2 R8 frame pattern", 32'(seg_on), 32'(VEC_EXP[i]));
            chk("R6 sdout is stage 15", 32'(sdout), 32'(VEC_EXP[i][15]));
        end

        // R3 hold while shifting, R4 update on select rise
        frame_open();
        put_word(32'h12, 8);
        chk("R3 hold mid frame", 32'(seg_on), 32'h7E81);
        put_word(32'h34, 8);
        chk("R3 hold full frame", 32'(seg_on), 32'h7E81);
        frame_close();
        chk("R4 update after select rise", 32'(seg_on), 32'h1234);

        // R5 serial clock edges with select high
        sdin = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
        end
        chk("R5 seg unchanged", 32'(seg_on), 32'h1234);
        chk("R5 sdout unchanged", 32'(sdout), 32'h0);

        // R6 overflow order on 20-bit frame
        long_w = 20'hA3C96;
        frame_open();
        for (int i = 0; i < 20; i++) begin
            put_bit(long_w[19 - i]);
            if (i >= 15) chk("R6 overflow order", 32'(sdout), 32'(long_w[34 - i]));
        end
        frame_close();
        chk("R6 long frame keeps last 16", 32'(seg_on), 32'(long_w[15:0]));

        // R7 lamp test
        lamp_test = 1'b1;
        wait_clk(1);
        chk("R7 lamp test all on", 32'(seg_on), 32'hFFFF);
        lamp_test = 1'b0;
        wait_clk(1);
        chk("R7 release restores", 32'(seg_on), 32'(long_w[15:0]));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule